// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

The block lets two processors share one memory module through two independent request ports. An arbitration stage in front of a small controller decides which pending request reaches the storage array. Once a request is accepted, the module stays busy for a fixed service time. A request that arrives during that time is not serviced. The requester keeps its request line asserted, and the request is accepted on the first idle cycle afterwards. A requester may also drop a waiting request and raise it again later.

The controller has two named states. `ST_IDLE` accepts a request. `ST_SERVE` holds the module busy while a service counter runs down. Its transitions are:
- `ST_IDLE -> ST_SERVE` on any request.
- `ST_SERVE -> ST_SERVE` while the counter is nonzero.
- `ST_SERVE -> ST_IDLE` when the counter reaches zero. At this point read data is returned.

When both ports ask on the same idle cycle, a fairness bit picks the winner and then flips.

Top module: `twoport_mem_arb`

## Requirements
- R1: While reset is held, `mem_busy`, both grants and both read-valid outputs are 0. After reset the fairness bit favours port 0.
- R2: If the module is idle at a clock edge and exactly one port requests, the block accepts that request. That port's grant is 1 for exactly the one cycle after that edge, and no request that was not present is granted.
- R3: `mem_busy` rises together with the grant and stays 1 for exactly SVC_CYC cycles. It is then 0 for at least one cycle.
- R4: A request sampled while `mem_busy` is 1 is not granted. A request held high is granted on the first edge at which the module is idle, which is SVC_CYC+1 cycles after the previous grant.
- R5: On a simultaneous request from an idle module, the port named by the fairness bit wins (0 = port 0, 1 = port 1). The bit then toggles, so back-to-back ties alternate.
- R6: Grants to a single requesting port leave the fairness bit unchanged.
- R7: A read (`pX_we` = 0) returns the most recently written word at its address. The data comes on that port's `pX_rdata`, with `pX_rvalid` high for exactly one cycle, SVC_CYC cycles after the grant. The other port never sees `rvalid`.
- R8: A write (`pX_we` = 1) stores `pX_wdata` at `pX_addr` and produces no `rvalid` on either port.
- R9: A request that is withdrawn before the module becomes idle is never granted. When the same request is raised again later, it is serviced normally.
- R10: At most one grant and at most one read-valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request, held until granted |
| p0_we | input | 1 | Port 0 write enable (1 write, 0 read) |
| p0_addr | input | AW | Port 0 word address |
| p0_wdata | input | DW | Port 0 write data |
| p0_gnt | output | 1 | Port 0 acceptance pulse |
| p0_rvalid | output | 1 | Port 0 read data valid pulse |
| p0_rdata | output | DW | Port 0 read data |
| p1_req | input | 1 | Port 1 request, held until granted |
| p1_we | input | 1 | Port 1 write enable (1 write, 0 read) |
| p1_addr | input | AW | Port 1 word address |
| p1_wdata | input | DW | Port 1 write data |
| p1_gnt | output | 1 | Port 1 acceptance pulse |
| p1_rvalid | output | 1 | Port 1 read data valid pulse |
| p1_rdata | output | DW | Port 1 read data |
| mem_busy | output | 1 | Module is servicing an accepted request |

## Verification
A grant and the rise of `mem_busy` are due one cycle after the edge that samples a request on an idle module. `rvalid` and its data come SVC_CYC cycles after the grant. `mem_busy` falls in the same cycle as `rvalid`, and a held competing request is granted one cycle later.

The bench drives inputs at the falling edge and compares outputs there too. A cycle-stepped reference model is advanced once per falling edge, so each prediction lines up with the register stage that produces it. Directed sequences measure the grant-to-grant and grant-to-`rvalid` distances explicitly.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } tpm_state_e;

    localparam int NUM_PORTS = 2;

    function automatic logic [NUM_PORTS-1:0] port_onehot(input logic port);
        return port ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/tpm_pick.sv
module tpm_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       idle,
    output logic       take,
    output logic       win
);
    logic prio_q;
    logic both;

    assign both = req[0] & req[1];
    assign take = req[0] | req[1];
    assign win  = both ? prio_q : req[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= 1'b0;
        end else if (idle && both) begin
            prio_q <= ~prio_q;
        end
    end
endmodule

// File: rtl/tpm_seq.sv
module tpm_seq
    import tpm_pkg::*;
#(
    parameter int SVC_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       win,
    input  logic       sel_we,
    output logic       busy,
    output logic       accept,
    output logic       fin_rd,
    output logic       owner,
    output logic [1:0] gnt,
    output logic [1:0] rvalid
);
    localparam int CW = (SVC_CYC < 2) ? 1 : $clog2(SVC_CYC);

    tpm_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          is_rd_q;
    logic          fin;

    assign accept = (state_q == ST_IDLE) && take;
    assign fin    = (state_q == ST_SERVE) && (cnt_q == '0);
    assign fin_rd = fin && is_rd_q;
    assign busy   = (state_q == ST_SERVE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = take ? ST_SERVE : ST_IDLE;
            ST_SERVE: state_d = (cnt_q == '0) ? ST_IDLE : ST_SERVE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            owner   <= 1'b0;
            is_rd_q <= 1'b0;
            gnt     <= '0;
            rvalid  <= '0;
        end else begin
            gnt    <= accept ? port_onehot(win) : 2'b00;
            rvalid <= fin_rd ? port_onehot(owner) : 2'b00;
            if (accept) begin
                cnt_q   <= CW'(SVC_CYC - 1);
                owner   <= win;
                is_rd_q <= ~sel_we;
            end else if (busy && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tpm_store.sv
module tpm_store #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/twoport_mem_arb.sv
module twoport_mem_arb #(
    parameter int AW      = 4,
    parameter int DW      = 16,
    parameter int SVC_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_req,
    input  logic          p0_we,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    output logic          p0_gnt,
    output logic          p0_rvalid,
    output logic [DW-1:0] p0_rdata,
    input  logic          p1_req,
    input  logic          p1_we,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    output logic          p1_gnt,
    output logic          p1_rvalid,
    output logic [DW-1:0] p1_rdata,
    output logic          mem_busy
);
    logic          take, win, accept, fin_rd, owner, busy;
    logic [1:0]    gnt, rvalid;
    logic          sel_we;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata, store_rd;
    logic [DW-1:0] rdata_q [2];

    assign sel_we    = win ? p1_we    : p0_we;
    assign sel_addr  = win ? p1_addr  : p0_addr;
    assign sel_wdata = win ? p1_wdata : p0_wdata;

    tpm_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({p1_req, p0_req}),
        .idle  (~busy),
        .take  (take),
        .win   (win)
    );

    tpm_seq #(.SVC_CYC(SVC_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .win    (win),
        .sel_we (sel_we),
        .busy   (busy),
        .accept (accept),
        .fin_rd (fin_rd),
        .owner  (owner),
        .gnt    (gnt),
        .rvalid (rvalid)
    );

    tpm_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .en    (accept),
        .we    (sel_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (store_rd)
    );

    for (genvar g = 0; g < 2; g++) begin : g_rdata
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q[g] <= '0;
            end else if (fin_rd && (owner == 1'(g))) begin
                rdata_q[g] <= store_rd;
            end
        end
    end

    assign p0_gnt    = gnt[0];
    assign p1_gnt    = gnt[1];
    assign p0_rvalid = rvalid[0];
    assign p1_rvalid = rvalid[1];
    assign p0_rdata  = rdata_q[0];
    assign p1_rdata  = rdata_q[1];
    assign mem_busy  = busy;
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker #(
    parameter int SVC_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic p0_req,
    input logic p1_req,
    input logic p0_gnt,
    input logic p1_gnt,
    input logic p0_rvalid,
    input logic p1_rvalid,
    input logic mem_busy
);
    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (mem_busy) begin
            busy_len <= (busy_len == 8'hFF) ? busy_len : busy_len + 8'd1;
        end else begin
            busy_len <= '0;
        end
    end

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(p0_gnt && p1_gnt)); // R10
    AST_RVALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(p0_rvalid && p1_rvalid)); // R10
    AST_GNT0_PULSE: assert property (@(posedge clk) disable iff (!rst_n) p0_gnt |=> !p0_gnt); // R2
    AST_GNT1_PULSE: assert property (@(posedge clk) disable iff (!rst_n) p1_gnt |=> !p1_gnt); // R2
    AST_GNT0_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n) p0_gnt |-> $past(p0_req)); // R2
    AST_GNT1_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n) p1_gnt |-> $past(p1_req)); // R2
    AST_GNT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (p0_gnt || p1_gnt) |-> mem_busy); // R3
    AST_NO_GNT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (p0_gnt || p1_gnt) |-> !$past(mem_busy)); // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (32'(busy_len) >= SVC_CYC) |-> !mem_busy); // R3
    AST_RVALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (p0_rvalid || p1_rvalid) |-> !mem_busy); // R7
endmodule

bind twoport_mem_arb tpm_checker #(.SVC_CYC(SVC_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .p0_req    (p0_req),
    .p1_req    (p1_req),
    .p0_gnt    (p0_gnt),
    .p1_gnt    (p1_gnt),
    .p0_rvalid (p0_rvalid),
    .p1_rvalid (p1_rvalid),
    .mem_busy  (mem_busy)
);

// File: tb/tb_twoport_mem_arb.sv
`timescale 1ns/1ps
module tb_twoport_mem_arb;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int SVC   = 2;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic r0 = 0, we0 = 0, r1 = 0, we1 = 0;
    logic [AW-1:0] a0 = '0, a1 = '0;
    logic [DW-1:0] d0 = '0, d1 = '0;
    logic p0_gnt, p0_rvalid, p1_gnt, p1_rvalid, mem_busy;
    logic [DW-1:0] p0_rdata, p1_rdata;

    always #2 clk = ~clk;

    twoport_mem_arb #(.AW(AW), .DW(DW), .SVC_CYC(SVC)) dut (
        .clk(clk), .rst_n(rst_n),
        .p0_req(r0), .p0_we(we0), .p0_addr(a0), .p0_wdata(d0),
        .p0_gnt(p0_gnt), .p0_rvalid(p0_rvalid), .p0_rdata(p0_rdata),
        .p1_req(r1), .p1_we(we1), .p1_addr(a1), .p1_wdata(d1),
        .p1_gnt(p1_gnt), .p1_rvalid(p1_rvalid), .p1_rdata(p1_rdata),
        .mem_busy(mem_busy)
    );

    int checks = 0, failures = 0, cyc = 0, busy_run = 0;
    int t_g0 = -1, t_g1 = -1, t_rv0 = -1, t_rv1 = -1;

    // reference model state
    bit m_busy = 0, m_prio = 0, m_owner = 0, m_isrd = 0;
    int m_cnt = 0;
    logic [DW-1:0] m_rd;
    logic [DW-1:0] m_mem [DEPTH];
    logic [1:0] e_g = 2'b00, e_rv = 2'b00;
    bit e_busy = 0;
    logic [DW-1:0] e_rd0 = '0, e_rd1 = '0;
    string tag_g = "R2";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit pick_port(input bit q0, input bit q1, input bit prio);
        if (q0 && q1) return prio;
        return q1;
    endfunction

    task automatic model_step();
        e_g  = 2'b00;
        e_rv = 2'b00;
        tag_g = "R2";
        if (!m_busy) begin
            if (r0 || r1) begin
                bit w;
                w = pick_port(r0, r1, m_prio);
                if (r0 && r1) begin
                    m_prio = !m_prio;
                    tag_g = "R5";
                end
                m_busy = 1; m_cnt = SVC - 1; m_owner = w;
                e_g[w] = 1'b1;
                if (w ? we1 : we0) begin
                    m_mem[w ? a1 : a0] = w ? d1 : d0;
                    m_isrd = 0;
                end else begin
                    m_rd = m_mem[w ? a1 : a0];
                    m_isrd = 1;
                end
            end
        end else begin
            tag_g = "R4";
            if (m_cnt == 0) begin
                m_busy = 0;
                if (m_isrd) begin
                    e_rv[m_owner] = 1'b1;
                    if (m_owner) e_rd1 = m_rd; else e_rd0 = m_rd;
                end
            end else begin
                m_cnt--;
            end
        end
        e_busy = m_busy;
    endtask

    task automatic step();
        chk(p0_gnt === e_g[0], tag_g, 32'(p0_gnt), 32'(e_g[0]));
        chk(p1_gnt === e_g[1], tag_g, 32'(p1_gnt), 32'(e_g[1]));
        chk(p0_rvalid === e_rv[0], m_isrd ? "R7 rvalid0" : "R8 rvalid0", 32'(p0_rvalid), 32'(e_rv[0]));
        chk(p1_rvalid === e_rv[1], m_isrd ? "R7 rvalid1" : "R8 rvalid1", 32'(p1_rvalid), 32'(e_rv[1]));
        chk(mem_busy === e_busy, "R3 busy", 32'(mem_busy), 32'(e_busy));
        if (e_rv[0]) chk(p0_rdata === e_rd0, "R7 rdata0", 32'(p0_rdata), 32'(e_rd0));
        if (e_rv[1]) chk(p1_rdata === e_rd1, "R7 rdata1", 32'(p1_rdata), 32'(e_rd1));
        if (mem_busy) busy_run++;
        else if (busy_run != 0) begin
            chk(busy_run == SVC, "R3 busy length", 32'(busy_run), 32'(SVC));
            busy_run = 0;
        end
        if (p0_gnt) begin t_g0 = cyc; r0 = 0; end
        if (p1_gnt) begin t_g1 = cyc; r1 = 0; end
        if (p0_rvalid) t_rv0 = cyc;
        if (p1_rvalid) t_rv1 = cyc;
        model_step();
        cyc++;
        @(negedge clk);
    endtask

    task automatic clear_times();
        t_g0 = -1; t_g1 = -1; t_rv0 = -1; t_rv1 = -1;
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_busy === 1'b0, "R1 busy in reset", 32'(mem_busy), 0);
        chk({p1_gnt, p0_gnt} === 2'b00, "R1 grants in reset", 32'({p1_gnt, p0_gnt}), 0);
        chk({p1_rvalid, p0_rvalid} === 2'b00, "R1 rvalid in reset", 32'({p1_rvalid, p0_rvalid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: fill memory with writes, no rvalid expected
        for (int i = 0; i < DEPTH; i++) begin
            r0 = 1; we0 = 1; a0 = AW'(i); d0 = DW'(16'hA500 + i);
            clear_times();
            step();
            idle_steps(SVC + 1);
            chk(t_rv0 == -1 && t_rv1 == -1, "R8 write has no rvalid", 32'(t_rv0), 32'hFFFFFFFF);
        end

        // R2/R7: single read, rvalid SVC cycles after grant
        clear_times();
        r1 = 1; we1 = 0; a1 = 4'd7;
        step();
        idle_steps(SVC + 2);
        chk(t_g1 >= 0, "R2 single request granted", 32'(t_g1), 0);
        chk(t_rv1 - t_g1 == SVC, "R7 read latency", 32'(t_rv1 - t_g1), 32'(SVC));
        chk(t_rv0 == -1, "R7 no rvalid on other port", 32'(t_rv0), 32'hFFFFFFFF);

        // R4: request raised while busy waits and is granted after
        clear_times();
        r0 = 1; we0 = 0; a0 = 4'd3;
        step();
        r1 = 1; we1 = 0; a1 = 4'd5;
        idle_steps(2 * SVC + 4);
        chk(t_g1 - t_g0 == SVC + 1, "R4 held request grant distance", 32'(t_g1 - t_g0), 32'(SVC + 1));

        // R9: withdrawn request never granted, re-raised is served
        clear_times();
        r0 = 1; we0 = 0; a0 = 4'd1;
        step();
        r1 = 1; we1 = 1; a1 = 4'd9; d1 = 16'h5A5A;
        step();
        r1 = 0;
        idle_steps(SVC + 4);
        chk(t_g1 == -1, "R9 withdrawn request not granted", 32'(t_g1), 32'hFFFFFFFF);
        r1 = 1;
        idle_steps(SVC + 3);
        chk(t_g1 >= 0, "R9 re-raised request served", 32'(t_g1), 0);
        r0 = 1; we0 = 0; a0 = 4'd9;
        idle_steps(SVC + 3);
        chk(p0_rdata === 16'h5A5A, "R9 re-raised write stored", 32'(p0_rdata), 32'h5A5A);

        // R5/R6: ties alternate; first tie goes to port 0 after single grants
        for (int k = 0; k < 3; k++) begin
            clear_times();
            r0 = 1; we0 = 0; a0 = 4'd2;
            r1 = 1; we1 = 0; a1 = 4'd4;
            idle_steps(2 * SVC + 4);
            if (k == 0)
                chk(t_g0 < t_g1, "R6 first tie to port 0", 32'(t_g0), 32'(t_g1));
            else if (k == 1)
                chk(t_g1 < t_g0, "R5 second tie to port 1", 32'(t_g1), 32'(t_g0));
            else
                chk(t_g0 < t_g1, "R5 third tie to port 0", 32'(t_g0), 32'(t_g1));
        end

        // random traffic, checked every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            if (!r0) begin
                if ($urandom % 100 < 35) begin
                    r0 = 1; we0 = 1'($urandom); a0 = AW'($urandom); d0 = DW'($urandom);
                end
            end else if ($urandom % 100 < 3) r0 = 0;
            if (!r1) begin
                if ($urandom % 100 < 35) begin
                    r1 = 1; we1 = 1'($urandom); a1 = AW'($urandom); d1 = DW'($urandom);
                end
            end else if ($urandom % 100 < 3) r1 = 0;
            step();
        end
        r0 = 0; r1 = 0;
        idle_steps(SVC + 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule